// File: doc/BRIEF.md
# Shift and Rotate Unit with Carry and Overflow Flags

This block is the combinational shift and rotate datapath of an integer execution unit. Each cycle it takes an operand, a count, an operand size, an operation code and the current carry flag. It returns the shifted or rotated result, the new carry flag, the new overflow flag and a strobe that says whether the flag register should be written. The caller picks the count source, which may be an immediate field or a count register, before it reaches this block.

Operand sizes are 8, 16, 32 and 64 bits, all held in one 64-bit port. The count is masked to the size before it is used, and a masked count of zero leaves both the operand and the flags untouched. The two rotate-through-carry operations treat the carry flag as one extra bit above the most significant bit. The carry output always holds the last bit that left the operand, and the overflow output is defined only for a masked count of one.

Top module: `shrot_unit`

## Requirements
- R1: `size_i` selects the width: 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64. Operand bits above the width have no effect, and result bits above the width are zero.
- R2: The unit uses only the low 6 bits of `count_i` when the width is 64 bits and only the low 5 bits for the other widths. Higher count bits are ignored.
- R3: For operation codes 0 to 6, a masked count of zero makes the result equal to the operand within the width, `carry_o` equal to `carry_i`, `ovf_o` 0 and `flag_we_o` 0. A nonzero masked count drives `flag_we_o` to 1.
- R4: Operation 0 is a left shift that fills the vacated low bits with zeros. `carry_o` is the last bit shifted out, which is 0 when the count is greater than the width.
- R5: Operation 1 is a logical right shift that fills with zeros. Operation 2 is an arithmetic right shift that fills with the sign bit of the width. `carry_o` is the last bit shifted out: 0 for operation 1 and the sign bit for operation 2 once the count is greater than the width.
- R6: Operation 3 rotates left and operation 4 rotates right, both within the width and by the masked count modulo the width. `carry_o` is the result's least significant bit for operation 3 and its most significant bit for operation 4.
- R7: Operation 5 rotates left and operation 6 rotates right through carry. Each rotates over width plus one bits, with `carry_i` as the bit just above the most significant bit, by the masked count modulo (width+1). `carry_o` is the new value of that extra bit.
- R8: When the masked count is 1, `ovf_o` is set as follows.
  - Operation 0: result MSB XOR `carry_o`.
  - Operation 1: the operand's original MSB.
  - Operation 2: 0.
  - Operation 3: result MSB XOR `carry_o`.
  - Operation 4: result MSB XOR the result bit just below it.
  - Operation 5: result MSB XOR `carry_o`.
  - Operation 6: the operand's original MSB XOR `carry_i`.

  For any other masked count, `ovf_o` is 0.
- R9: Operation code 7 makes no change: the result is the operand within the width, `carry_o` equals `carry_i`, `ovf_o` is 0 and `flag_we_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand_i | input | 64 | Operand, right-aligned to the selected width |
| count_i | input | 8 | Raw shift or rotate count, before masking |
| size_i | input | 2 | Width code (0: 8, 1: 16, 2: 32, 3: 64 bits) |
| op_i | input | 3 | Operation code, 0 to 7 |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 64 | Result, zero above the selected width |
| carry_o | output | 1 | New carry flag |
| ovf_o | output | 1 | New overflow flag |
| flag_we_o | output | 1 | High when the flags should be written |

## Verification
The bound checker assumes that every input is a known 0 or 1 at the moment it evaluates, and it skips any evaluation where an input is X or Z. It also assumes that the size code always names one of the four widths, so it can rebuild a width mask of its own. The bench changes inputs only on the falling clock edge and drives every input bit, including the operand bits above the width and the count bits above the mask, to known values. That keeps the checker inside its assumptions throughout the run while still stressing the bits that must be ignored.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

   typedef enum logic [2:0] {
      SR_SHL = 3'd0,
      SR_SHR = 3'd1,
      SR_SAR = 3'd2,
      SR_ROL = 3'd3,
      SR_ROR = 3'd4,
      SR_RCL = 3'd5,
      SR_RCR = 3'd6,
      SR_NOP = 3'd7
   } sr_op_e;

   // number of width lanes for a maximum width (8, 16, ... up to max)
   function automatic int lane_count(input int wmax);
      return $clog2(wmax / 8) + 1;
   endfunction

endpackage

// File: rtl/shrot_cnt_mask.sv
module shrot_cnt_mask #(
   parameter int CNT_IN_W = 8,
   parameter int CW       = 6,
   parameter int NS       = 4
) (
   input  logic [CNT_IN_W-1:0] count_i,
   input  logic [1:0]          sel_i,
   output logic [CW-1:0]       masked_o
);

   localparam logic [CW-1:0] FULL_MASK = {CW{1'b1}};
   localparam logic [CW-1:0] NARROW_MASK = {1'b0, {(CW-1){1'b1}}};

   logic widest;

   always_comb begin
      widest   = (int'(sel_i) == NS - 1);
      masked_o = count_i[CW-1:0] & (widest ? FULL_MASK : NARROW_MASK);
   end

endmodule

// File: rtl/shrot_lane.sv
module shrot_lane
   import shrot_pkg::*;
#(
   parameter int W  = 8,
   parameter int CW = 6
) (
   input  logic [W-1:0]  opd_i,
   input  logic [CW-1:0] cnt_i,
   input  logic          cin_i,
   input  sr_op_e        op_i,
   output logic [W-1:0]  res_o,
   output logic          cout_o,
   output logic          ovf_o
);

   localparam int RW = $clog2(W);

   logic [W:0]     shl_t;
   logic [W:0]     shr_t;
   logic [W:0]     sar_t;
   logic [W:0]     cat;
   logic [2*W-1:0] rol_t;
   logic [2*W-1:0] ror_t;
   logic [2*W+1:0] rcl_t;
   logic [2*W+1:0] rcr_t;
   logic [RW-1:0]  rot_amt;
   logic [CW-1:0]  rc_amt;
   logic           one;

   always_comb begin
      cat     = {cin_i, opd_i};
      rot_amt = cnt_i[RW-1:0];
      rc_amt  = CW'(int'(cnt_i) % (W + 1));
      one     = (cnt_i == CW'(1));

      // the extra guard bit catches the last bit shifted out
      shl_t = {1'b0, opd_i} << cnt_i;
      shr_t = {opd_i, 1'b0} >> cnt_i;
      sar_t = $signed({opd_i, 1'b0}) >>> cnt_i;

      rol_t = {opd_i, opd_i} << rot_amt;
      ror_t = {opd_i, opd_i} >> rot_amt;
      rcl_t = {cat, cat} << rc_amt;
      rcr_t = {cat, cat} >> rc_amt;

      res_o  = opd_i;
      cout_o = cin_i;
      ovf_o  = 1'b0;

      case (op_i)
         SR_SHL: begin
            res_o  = shl_t[W-1:0];
            cout_o = shl_t[W];
            ovf_o  = one & (shl_t[W-1] ^ shl_t[W]);
         end
         SR_SHR: begin
            res_o  = shr_t[W:1];
            cout_o = shr_t[0];
            ovf_o  = one & opd_i[W-1];
         end
         SR_SAR: begin
            res_o  = sar_t[W:1];
            cout_o = sar_t[0];
            ovf_o  = 1'b0;
         end
         SR_ROL: begin
            res_o  = rol_t[2*W-1:W];
            cout_o = rol_t[W];
            ovf_o  = one & (rol_t[2*W-1] ^ rol_t[W]);
         end
         SR_ROR: begin
            res_o  = ror_t[W-1:0];
            cout_o = ror_t[W-1];
            ovf_o  = one & (ror_t[W-1] ^ ror_t[W-2]);
         end
         SR_RCL: begin
            res_o  = rcl_t[2*W:W+1];
            cout_o = rcl_t[2*W+1];
            ovf_o  = one & (rcl_t[2*W] ^ rcl_t[2*W+1]);
         end
         SR_RCR: begin
            res_o  = rcr_t[W-1:0];
            cout_o = rcr_t[W];
            ovf_o  = one & (opd_i[W-1] ^ cin_i);
         end
         default: begin
            res_o  = opd_i;
            cout_o = cin_i;
            ovf_o  = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/shrot_out_sel.sv
module shrot_out_sel
   import shrot_pkg::*;
#(
   parameter int W_MAX = 64,
   parameter int CW    = 6,
   parameter int NS    = 4
) (
   input  logic [NS-1:0][W_MAX-1:0] lane_res_i,
   input  logic [NS-1:0]            lane_c_i,
   input  logic [NS-1:0]            lane_o_i,
   input  logic [1:0]               sel_i,
   input  logic [CW-1:0]            cnt_i,
   input  sr_op_e                   op_i,
   input  logic [W_MAX-1:0]         opd_i,
   input  logic                     cin_i,
   output logic [W_MAX-1:0]         res_o,
   output logic                     cout_o,
   output logic                     ovf_o,
   output logic                     we_o
);

   logic [W_MAX-1:0] wmask;
   logic             idle;

   always_comb begin
      wmask = {W_MAX{1'b1}} >> (W_MAX - (8 << sel_i));
      idle  = (cnt_i == '0) || (op_i == SR_NOP);
      if (idle) begin
         res_o  = opd_i & wmask;
         cout_o = cin_i;
         ovf_o  = 1'b0;
         we_o   = 1'b0;
      end else begin
         res_o  = lane_res_i[sel_i] & wmask;
         cout_o = lane_c_i[sel_i];
         ovf_o  = lane_o_i[sel_i];
         we_o   = 1'b1;
      end
   end

endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
   import shrot_pkg::*;
#(
   parameter int W_MAX    = 64,
   parameter int CNT_IN_W = 8
) (
   input  logic [W_MAX-1:0]    operand_i,
   input  logic [CNT_IN_W-1:0] count_i,
   input  logic [1:0]          size_i,
   input  logic [2:0]          op_i,
   input  logic                carry_i,
   output logic [W_MAX-1:0]    result_o,
   output logic                carry_o,
   output logic                ovf_o,
   output logic                flag_we_o
);

   localparam int NS = lane_count(W_MAX);
   localparam int CW = $clog2(W_MAX);

   // elaboration-time parameter checks
   if (W_MAX < 16 || (W_MAX & (W_MAX - 1)) != 0) begin : g_bad_wmax
      $error("shrot_unit: W_MAX must be a power of two of at least 16");
   end
   if (NS > 4) begin : g_bad_ns
      $error("shrot_unit: size code covers at most four widths");
   end
   if (CNT_IN_W < CW) begin : g_bad_cnt
      $error("shrot_unit: CNT_IN_W narrower than the masked count");
   end

   logic [1:0]               sel;
   logic [CW-1:0]            cnt_m;
   sr_op_e                   op_e;
   logic [NS-1:0][W_MAX-1:0] lane_res;
   logic [NS-1:0]            lane_c;
   logic [NS-1:0]            lane_o;

   always_comb begin
      sel  = (int'(size_i) >= NS) ? 2'(NS - 1) : size_i;
      op_e = sr_op_e'(op_i);
   end

   shrot_cnt_mask #(
      .CNT_IN_W (CNT_IN_W),
      .CW       (CW),
      .NS       (NS)
   ) u_cnt_mask (
      .count_i  (count_i),
      .sel_i    (sel),
      .masked_o (cnt_m)
   );

   for (genvar s = 0; s < NS; s++) begin : g_lane
      localparam int LW = 8 << s;
      logic [LW-1:0] l_res;

      shrot_lane #(
         .W  (LW),
         .CW (CW)
      ) u_lane (
         .opd_i  (operand_i[LW-1:0]),
         .cnt_i  (cnt_m),
         .cin_i  (carry_i),
         .op_i   (op_e),
         .res_o  (l_res),
         .cout_o (lane_c[s]),
         .ovf_o  (lane_o[s])
      );

      assign lane_res[s] = W_MAX'(l_res);
   end

   shrot_out_sel #(
      .W_MAX (W_MAX),
      .CW    (CW),
      .NS    (NS)
   ) u_out_sel (
      .lane_res_i (lane_res),
      .lane_c_i   (lane_c),
      .lane_o_i   (lane_o),
      .sel_i      (sel),
      .cnt_i      (cnt_m),
      .op_i       (op_e),
      .opd_i      (operand_i),
      .cin_i      (carry_i),
      .res_o      (result_o),
      .cout_o     (carry_o),
      .ovf_o      (ovf_o),
      .we_o       (flag_we_o)
   );

endmodule

// File: rtl/shrot_unit_chk.sv
module shrot_unit_chk #(
   parameter int W_MAX    = 64,
   parameter int CNT_IN_W = 8
) (
   input logic [W_MAX-1:0]    operand_i,
   input logic [CNT_IN_W-1:0] count_i,
   input logic [1:0]          size_i,
   input logic [2:0]          op_i,
   input logic                carry_i,
   input logic [W_MAX-1:0]    result_o,
   input logic                carry_o,
   input logic                ovf_o,
   input logic                flag_we_o
);

   logic [W_MAX-1:0] wm;
   logic [W_MAX-1:0] op_w;
   logic             res_msb;
   logic             opd_msb;
   logic             known;

   always_comb begin
      wm      = {W_MAX{1'b1}} >> (W_MAX - (8 << size_i));
      op_w    = operand_i & wm;
      res_msb = |(result_o & (wm ^ (wm >> 1)));
      opd_msb = |(operand_i & (wm ^ (wm >> 1)));
      known   = !$isunknown({operand_i, count_i, size_i, op_i, carry_i,
                             result_o, carry_o, ovf_o, flag_we_o});
      if (known) begin
         // R1: nothing above the selected width
         a_r1_upper_zero: assert ((result_o & ~wm) == '0);
         // R3: a cycle without a flag write leaves operand and carry as they were
         a_r3_idle_passthru: assert (flag_we_o ||
            (result_o == op_w && carry_o == carry_i && !ovf_o));
         // R8: overflow only on a masked count of one
         a_r8_ovf_count_one: assert (!ovf_o ||
            (count_i[0] && count_i[4:1] == 4'd0));
         // R5: arithmetic right shift keeps the sign
         a_r5_sar_sign: assert (!(op_i == 3'd2 && flag_we_o) ||
            (res_msb == opd_msb));
         // R6: plain rotates keep the population count
         a_r6_rot_ones: assert (!(op_i == 3'd3 || op_i == 3'd4) ||
            ($countones(result_o) == $countones(op_w)));
         // R7: rotates through carry keep the count of ones including the carry
         a_r7_rc_ones: assert (!(op_i == 3'd5 || op_i == 3'd6) ||
            ($countones({result_o, carry_o}) == $countones({op_w, carry_i})));
         // R9: code 7 never writes flags
         a_r9_nop_no_we: assert (!(op_i == 3'd7) || !flag_we_o);
      end
   end

endmodule

bind shrot_unit shrot_unit_chk #(
   .W_MAX    (W_MAX),
   .CNT_IN_W (CNT_IN_W)
) u_chk (
   .operand_i (operand_i),
   .count_i   (count_i),
   .size_i    (size_i),
   .op_i      (op_i),
   .carry_i   (carry_i),
   .result_o  (result_o),
   .carry_o   (carry_o),
   .ovf_o     (ovf_o),
   .flag_we_o (flag_we_o)
);

// File: tb/shrot_unit_tb.sv
module shrot_unit_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] operand_i = '0;
   logic [7:0]  count_i = '0;
   logic [1:0]  size_i = '0;
   logic [2:0]  op_i = '0;
   logic        carry_i = 1'b0;
   logic [63:0] result_o;
   logic        carry_o;
   logic        ovf_o;
   logic        flag_we_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;  // 250 MHz

   shrot_unit u_dut (
      .operand_i (operand_i),
      .count_i   (count_i),
      .size_i    (size_i),
      .op_i      (op_i),
      .carry_i   (carry_i),
      .result_o  (result_o),
      .carry_o   (carry_o),
      .ovf_o     (ovf_o),
      .flag_we_o (flag_we_o)
   );

   typedef struct packed {
      logic [2:0]  op;
      logic [1:0]  sz;
      logic [7:0]  cnt;
      logic [63:0] opd;
      logic        cin;
      logic [63:0] res;
      logic        c;
      logic        o;
      logic        en;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 28;
   localparam vec_t VT [NV] = '{
      '{3'd0, 2'd0, 8'd1,  64'h81, 1'b0, 64'h02, 1'b1, 1'b1, 1'b1, 4'd8},  // R8 shl ovf
      '{3'd0, 2'd0, 8'd3,  64'h0F, 1'b0, 64'h78, 1'b0, 1'b0, 1'b1, 4'd4},  // R4
      '{3'd0, 2'd0, 8'd8,  64'h01, 1'b0, 64'h00, 1'b1, 1'b0, 1'b1, 4'd4},  // R4 count = width
      '{3'd0, 2'd0, 8'd9,  64'hFF, 1'b1, 64'h00, 1'b0, 1'b0, 1'b1, 4'd4},  // R4 count > width
      '{3'd1, 2'd1, 8'd1,  64'hFFFF_FFFF_FFFF_8001, 1'b0, 64'h4000, 1'b1, 1'b1, 1'b1, 4'd1}, // R1 upper ignored
      '{3'd2, 2'd1, 8'd4,  64'h8010, 1'b0, 64'hF801, 1'b0, 1'b0, 1'b1, 4'd5},  // R5 sar
      '{3'd2, 2'd0, 8'd1,  64'h81, 1'b0, 64'hC0, 1'b1, 1'b0, 1'b1, 4'd8},  // R8 sar ovf 0
      '{3'd2, 2'd2, 8'd31, 64'h8000_0000, 1'b0, 64'hFFFF_FFFF, 1'b0, 1'b0, 1'b1, 4'd5}, // R5
      '{3'd1, 2'd3, 8'd63, 64'h8000_0000_0000_0000, 1'b0, 64'h1, 1'b0, 1'b0, 1'b1, 4'd5}, // R5
      '{3'd0, 2'd3, 8'h41, 64'h4000_0000_0000_0000, 1'b0, 64'h8000_0000_0000_0000, 1'b0, 1'b1, 1'b1, 4'd2}, // R2
      '{3'd0, 2'd2, 8'h21, 64'h1, 1'b0, 64'h2, 1'b0, 1'b0, 1'b1, 4'd2},  // R2 5-bit mask
      '{3'd0, 2'd2, 8'h20, 64'h1234_5678, 1'b1, 64'h1234_5678, 1'b1, 1'b0, 1'b0, 4'd2}, // R2 masked to 0
      '{3'd3, 2'd0, 8'd1,  64'h81, 1'b0, 64'h03, 1'b1, 1'b1, 1'b1, 4'd8},  // R8 rol ovf
      '{3'd3, 2'd0, 8'd12, 64'h12, 1'b0, 64'h21, 1'b1, 1'b0, 1'b1, 4'd6},  // R6 mod width
      '{3'd3, 2'd0, 8'd8,  64'h81, 1'b0, 64'h81, 1'b1, 1'b0, 1'b1, 4'd6},  // R6 full turn
      '{3'd4, 2'd1, 8'd1,  64'h0001, 1'b0, 64'h8000, 1'b1, 1'b1, 1'b1, 4'd8}, // R8 ror ovf
      '{3'd4, 2'd3, 8'd4,  64'h0123_4567_89AB_CDEF, 1'b0, 64'hF012_3456_789A_BCDE, 1'b1, 1'b0, 1'b1, 4'd6}, // R6
      '{3'd5, 2'd0, 8'd1,  64'h80, 1'b0, 64'h00, 1'b1, 1'b1, 1'b1, 4'd8},  // R8 rcl ovf
      '{3'd5, 2'd0, 8'd9,  64'h55, 1'b1, 64'h55, 1'b1, 1'b0, 1'b1, 4'd7},  // R7 mod 9
      '{3'd5, 2'd0, 8'd2,  64'h40, 1'b1, 64'h02, 1'b1, 1'b0, 1'b1, 4'd7},  // R7
      '{3'd6, 2'd0, 8'd1,  64'h01, 1'b1, 64'h80, 1'b1, 1'b1, 1'b1, 4'd8},  // R8 rcr ovf
      '{3'd6, 2'd1, 8'd17, 64'hABCD, 1'b0, 64'hABCD, 1'b0, 1'b0, 1'b1, 4'd7}, // R7 mod 17
      '{3'd6, 2'd1, 8'd3,  64'h0005, 1'b0, 64'h4000, 1'b1, 1'b0, 1'b1, 4'd7}, // R7
      '{3'd7, 2'd0, 8'd3,  64'hFFA5, 1'b1, 64'hA5, 1'b1, 1'b0, 1'b0, 4'd9},  // R9
      '{3'd0, 2'd0, 8'd0,  64'h3C, 1'b0, 64'h3C, 1'b0, 1'b0, 1'b0, 4'd3},  // R3
      '{3'd1, 2'd0, 8'd10, 64'hFF, 1'b1, 64'h00, 1'b0, 1'b0, 1'b1, 4'd5},  // R5 shr beyond
      '{3'd2, 2'd0, 8'd10, 64'h80, 1'b0, 64'hFF, 1'b1, 1'b0, 1'b1, 4'd5},  // R5 sar beyond
      '{3'd5, 2'd3, 8'd63, 64'h1, 1'b0, 64'h8000_0000_0000_0000, 1'b0, 1'b0, 1'b1, 4'd7}  // R7 64-bit
   };

   task automatic check(input string tag, input logic [63:0] er, input logic ec,
                        input logic eo, input logic ee);
      n_chk++;
      if (result_o !== er || carry_o !== ec || ovf_o !== eo || flag_we_o !== ee) begin
         n_bad++;
         $display("FAIL %s: got res=%h c=%b o=%b we=%b, expected res=%h c=%b o=%b we=%b",
                  tag, result_o, carry_o, ovf_o, flag_we_o, er, ec, eo, ee);
      end
   endtask

   task automatic apply(input logic [2:0] op, input logic [1:0] sz, input logic [7:0] cnt,
                        input logic [63:0] opd, input logic cin);
      @(negedge clk);
      op_i = op; size_i = sz; count_i = cnt; operand_i = opd; carry_i = cin;
      #1;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;

      // R3: all-zero inputs, no flag write
      @(negedge clk); #1;
      check("R3 idle", 64'h0, 1'b0, 1'b0, 1'b0);

      for (int i = 0; i < NV; i++) begin
         apply(VT[i].op, VT[i].sz, VT[i].cnt, VT[i].opd, VT[i].cin);
         check($sformatf("R%0d vec%0d", VT[i].req, i), VT[i].res, VT[i].c, VT[i].o, VT[i].en);
      end

      // R2 R4: count sweep, 8-bit left shift of 1, 5-bit mask
      for (int k = 0; k < 256; k++) begin
         int m;
         logic [63:0] er;
         m = k & 31;
         er = (m == 0) ? 64'h1 : ((m < 8) ? (64'h1 << m) : 64'h0);
         apply(3'd0, 2'd0, 8'(k), 64'h1, 1'b0);
         check($sformatf("R4 shl sweep %0d", k), er, (m == 8), 1'b0, (m != 0));
      end

      // R2 R6: count sweep, 64-bit right rotate of 1, 6-bit mask
      for (int k = 0; k < 256; k++) begin
         int m;
         logic [63:0] er;
         m = k & 63;
         er = 64'h1 << ((64 - m) % 64);
         apply(3'd4, 2'd3, 8'(k), 64'h1, 1'b0);
         check($sformatf("R6 ror sweep %0d", k), er,
               (m == 0) ? 1'b0 : er[63], (m == 1), (m != 0));
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule